// File: doc/BRIEF.md
# Serial Node Address Decoder

This block watches the address field at the start of each message arriving on a node's receive path. Bits come in one at a time, most significant first. The block works out which form of address is arriving, compares it with the node's own identity and, on a hit, asserts a wake request so that the node's functional logic powers up. Messages for other nodes leave the rest of the node asleep.

Three address forms are recognised:

- **Short address.** Eight bits: a 4-bit prefix followed by a 4-bit unit number.
- **Broadcast.** A short address whose prefix is zero. The unit nibble then selects a broadcast channel, and a per-channel enable mask says which channels the node listens to.
- **Full address.** A short prefix of all ones is an escape that stretches the address to 24 bits. The first 20 bits, which begin with that escape nibble, are compared with a hardwired node identity, and the last 4 bits give the unit number.

The verdict is held until the message ends. After a verdict the rest of the message (payload, or the remainder of a rejected message) is ignored for decoding purposes.

The serial input is a valid/ready stream. A bit is taken on every clock edge where `bit_valid` and `bit_ready` are both high. `bit_ready` is always high, so the decoder never back-pressures and the source never has to wait. `msg_end` is a plain control pulse that closes the current message.

Top module: `addr_filter`

## Requirements
- R1: After reset, `hit`, `bcast` and `wake` are 0, `unit_id` is 0, and `bit_ready` is 1.
- R2: A bit is accepted only in a cycle with `bit_valid`=1 and `msg_end`=0. Idle cycles between bits do not disturb address collection, and address bits arrive most significant first.
- R3: A short address is 8 bits, with prefix in bits [7:4] and unit in bits [3:0]. A prefix of 1..14 that equals `short_pfx`, while `short_pfx_vld`=1, gives `hit`=1 with `unit_id` equal to the unit. The output is visible in the cycle after the edge that takes the 8th bit.
- R4: With `short_pfx_vld`=0, or with `short_pfx` equal to 0 or 15, no short address matches. Full and broadcast addresses are still decoded.
- R5: A prefix of 0 is a broadcast. The bits [3:0] select channel c, and the message is accepted (`hit`=1, `bcast`=1, `unit_id`=c) only if `chan_mask[c]`=1. `bcast` is never 1 without `hit`.
- R6: A prefix of 15 is an escape to a 24-bit address. Bits [23:4] must equal `full_id`, whose bits [19:16] are 15, and bits [3:0] are the unit. No verdict is given after the 8th bit; the verdict follows the edge that takes the 24th bit.
- R7: `wake` is a single-cycle pulse, raised together with the rising edge of `hit`, and only on a match.
- R8: A mismatch leaves `hit` and `wake` at 0. All later bits of that message are ignored, even if they form a matching address.
- R9: `msg_end` clears `hit`, `bcast` and `unit_id` on the next edge and restarts collection. A bit offered in the same cycle as `msg_end` is discarded.
- R10: After a match, further bits of the message leave `hit` and `unit_id` unchanged.
- R11: `unit_id` is 0 whenever `hit` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_valid | input | 1 | Serial bit present on `bit_data` |
| bit_ready | output | 1 | Decoder can take a bit (always 1) |
| bit_data | input | 1 | Serial message bit, most significant first |
| msg_end | input | 1 | Current message is over; re-arm the decoder |
| short_pfx | input | 4 | Short prefix assigned to this node |
| short_pfx_vld | input | 1 | `short_pfx` has been assigned |
| full_id | input | 20 | Hardwired full node identity (top nibble 15) |
| chan_mask | input | 16 | Broadcast channels this node listens to |
| hit | output | 1 | Current message is addressed to this node |
| bcast | output | 1 | Accepted message is a broadcast |
| unit_id | output | 4 | Unit number or broadcast channel of the accepted message |
| wake | output | 1 | One-cycle request to wake the node's functional logic |

## Verification
The decoder is driven with:

- matching and non-matching short addresses;
- broadcasts on listened and unlisted channels;
- full addresses that match and that differ only in the identity field.

Together these patterns separate the three decode paths and show that each compares the right field.

Further sequences probe the timing and state handling:

- A matching address sent after a mismatch, with no message end in between, shows that a rejected message stays rejected.
- A stray bit in the same cycle as the message end would shift the following address if it were counted.
- Bits separated by idle cycles, and a check after the eighth bit of a full address, show that the verdict is taken at the right bit count.

// File: rtl/addr_filter_pkg.sv
package addr_filter_pkg;
  typedef enum logic {
    PH_COLLECT = 1'b0,
    PH_HOLD    = 1'b1
  } phase_t;
endpackage

// File: rtl/addr_shreg.sv
module addr_shreg #(
  parameter int LEN   = 24,
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             en,
  input  logic             din,
  output logic [LEN-1:0]   sh_next,
  output logic [CNT_W-1:0] cnt_next
);
  logic [LEN-1:0]   sh_q;
  logic [CNT_W-1:0] cnt_q;

  assign sh_next  = {sh_q[LEN-2:0], din};
  assign cnt_next = cnt_q + CNT_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else if (clr) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else if (en) begin
      sh_q  <= sh_next;
      cnt_q <= cnt_next;
    end
  end
endmodule

// File: rtl/addr_match.sv
module addr_match #(
  parameter int PFX_W  = 4,
  parameter int FULL_W = 20,
  parameter int UNIT_W = 4
) (
  input  logic [FULL_W+UNIT_W-1:0] addr,
  input  logic                     long_form,
  input  logic [PFX_W-1:0]         own_short,
  input  logic                     own_short_ok,
  input  logic [FULL_W-1:0]        own_full,
  input  logic [(1<<UNIT_W)-1:0]   chan_mask,
  output logic                     m_hit,
  output logic                     m_bcast,
  output logic [UNIT_W-1:0]        m_unit
);
  localparam int SHORT_LEN = PFX_W + UNIT_W;
  localparam int LONG_LEN  = FULL_W + UNIT_W;
  localparam int NCH       = 1 << UNIT_W;

  logic [PFX_W-1:0] rx_pfx;
  logic [NCH-1:0]   ch_on;
  logic             listening;

  assign rx_pfx = addr[SHORT_LEN-1:UNIT_W];
  assign m_unit = addr[UNIT_W-1:0];

  for (genvar g = 0; g < NCH; g++) begin : g_chan
    assign ch_on[g] = chan_mask[g] && (m_unit == UNIT_W'(g));
  end
  assign listening = |ch_on;

  always_comb begin
    m_hit   = 1'b0;
    m_bcast = 1'b0;
    if (long_form) begin
      m_hit = (addr[LONG_LEN-1:UNIT_W] == own_full);
    end else if (rx_pfx == '0) begin
      m_bcast = 1'b1;
      m_hit   = listening;
    end else begin
      m_hit = own_short_ok && (rx_pfx == own_short);
    end
  end
endmodule

// File: rtl/addr_filter.sv
module addr_filter
  import addr_filter_pkg::*;
#(
  parameter int PFX_W  = 4,
  parameter int FULL_W = 20,
  parameter int UNIT_W = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   bit_valid,
  output logic                   bit_ready,
  input  logic                   bit_data,
  input  logic                   msg_end,
  input  logic [PFX_W-1:0]       short_pfx,
  input  logic                   short_pfx_vld,
  input  logic [FULL_W-1:0]      full_id,
  input  logic [(1<<UNIT_W)-1:0] chan_mask,
  output logic                   hit,
  output logic                   bcast,
  output logic [UNIT_W-1:0]      unit_id,
  output logic                   wake
);
  localparam int SHORT_LEN          = PFX_W + UNIT_W;
  localparam int LONG_LEN           = FULL_W + UNIT_W;
  localparam int CNT_W              = $clog2(LONG_LEN + 1);
  localparam logic [PFX_W-1:0] ESC  = {PFX_W{1'b1}};

  phase_t              phase;
  logic                fire;
  logic                decide;
  logic                escaped;
  logic                long_done;
  logic                short_done;
  logic                own_short_ok;
  logic [LONG_LEN-1:0] sh_next;
  logic [CNT_W-1:0]    cnt_next;
  logic                m_hit;
  logic                m_bcast;
  logic [UNIT_W-1:0]   m_unit;

  // The decoder never stalls its source.
  assign bit_ready = 1'b1;
  assign fire      = bit_valid && !msg_end && (phase == PH_COLLECT);

  addr_shreg #(.LEN(LONG_LEN), .CNT_W(CNT_W)) u_shreg (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (msg_end),
    .en       (fire),
    .din      (bit_data),
    .sh_next  (sh_next),
    .cnt_next (cnt_next)
  );

  assign escaped      = (sh_next[SHORT_LEN-1:UNIT_W] == ESC);
  assign short_done   = (cnt_next == CNT_W'(SHORT_LEN)) && !escaped;
  assign long_done    = (cnt_next == CNT_W'(LONG_LEN));
  assign decide       = fire && (short_done || long_done);
  assign own_short_ok = short_pfx_vld && (short_pfx != '0) && (short_pfx != ESC);

  addr_match #(.PFX_W(PFX_W), .FULL_W(FULL_W), .UNIT_W(UNIT_W)) u_match (
    .addr         (sh_next),
    .long_form    (long_done),
    .own_short    (short_pfx),
    .own_short_ok (own_short_ok),
    .own_full     (full_id),
    .chan_mask    (chan_mask),
    .m_hit        (m_hit),
    .m_bcast      (m_bcast),
    .m_unit       (m_unit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= PH_COLLECT;
      hit     <= 1'b0;
      bcast   <= 1'b0;
      unit_id <= '0;
      wake    <= 1'b0;
    end else begin
      wake <= 1'b0;
      if (msg_end) begin
        phase   <= PH_COLLECT;
        hit     <= 1'b0;
        bcast   <= 1'b0;
        unit_id <= '0;
      end else if (decide) begin
        phase   <= PH_HOLD;
        hit     <= m_hit;
        bcast   <= m_hit && m_bcast;
        unit_id <= m_hit ? m_unit : '0;
        wake    <= m_hit;
      end
    end
  end
endmodule

// File: rtl/addr_filter_chk.sv
module addr_filter_chk #(
  parameter int UNIT_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bit_valid,
  input logic              msg_end,
  input logic              hit,
  input logic              bcast,
  input logic [UNIT_W-1:0] unit_id,
  input logic              wake
);
  AST_WAKE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) wake |=> !wake); // R7
  AST_WAKE_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n) wake |-> $rose(hit)); // R7
  AST_BCAST_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n) bcast |-> hit); // R5
  AST_END_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) msg_end |=> (!hit && !bcast && unit_id == '0)); // R9
  AST_HIT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) (hit && !msg_end) |=> hit); // R10
  AST_UNIT_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !hit |-> unit_id == '0); // R11
  AST_HIT_NEEDS_BIT: assert property (@(posedge clk) disable iff (!rst_n) $rose(hit) |-> ($past(bit_valid) && !$past(msg_end))); // R2
endmodule

bind addr_filter addr_filter_chk #(.UNIT_W(UNIT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bit_valid (bit_valid),
  .msg_end   (msg_end),
  .hit       (hit),
  .bcast     (bcast),
  .unit_id   (unit_id),
  .wake      (wake)
);

// File: tb/addr_filter_test.sv
module addr_filter_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bit_valid = 1'b0;
  logic        bit_ready;
  logic        bit_data = 1'b0;
  logic        msg_end = 1'b0;
  logic [3:0]  short_pfx = 4'h5;
  logic        short_pfx_vld = 1'b1;
  logic [19:0] full_id = 20'hF3A5C;
  logic [15:0] chan_mask = 16'h0024;
  logic        hit;
  logic        bcast;
  logic [3:0]  unit_id;
  logic        wake;

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic       hit;
    logic       bc;
    logic [3:0] unit;
    string      tag;
  } exp_t;

  exp_t sb_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  addr_filter uut (
    .clk           (clk),
    .rst_n         (rst_n),
    .bit_valid     (bit_valid),
    .bit_ready     (bit_ready),
    .bit_data      (bit_data),
    .msg_end       (msg_end),
    .short_pfx     (short_pfx),
    .short_pfx_vld (short_pfx_vld),
    .full_id       (full_id),
    .chan_mask     (chan_mask),
    .hit           (hit),
    .bcast         (bcast),
    .unit_id       (unit_id),
    .wake          (wake)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic send_bits(input logic [23:0] v, input int n, input bit gaps);
    for (int i = n - 1; i >= 0; i--) begin
      bit_valid = 1'b1;
      bit_data  = v[i];
      @(negedge clk);
      if (gaps) begin
        bit_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
      end
    end
    bit_valid = 1'b0;
  endtask

  task automatic expect_out(input logic h, input logic b, input logic [3:0] u, input string tag);
    exp_t e;
    e.hit = h;
    e.bc = b;
    e.unit = u;
    e.tag = tag;
    sb_q.push_back(e);
  endtask

  task automatic end_msg(input string tag);
    msg_end = 1'b1;
    @(negedge clk);
    msg_end = 1'b0;
    check(hit == 1'b0 && unit_id == 4'h0 && bcast == 1'b0, tag, {hit, unit_id}, 0);
  endtask

  // Monitor: compares the outputs right after each verdict edge.
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        check(hit == e.hit, {e.tag, " hit"}, hit, e.hit);
        check(bcast == e.bc, {e.tag, " bcast"}, bcast, e.bc);
        check(unit_id == e.unit, {e.tag, " unit_id"}, unit_id, e.unit);
        check(wake == e.hit, {e.tag, " wake"}, wake, e.hit);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(hit == 0 && bcast == 0 && wake == 0 && unit_id == 0, "R1 reset outputs", {hit, bcast, wake, unit_id}, 0);
    check(bit_ready == 1'b1, "R1 ready after reset", bit_ready, 1);
    rst_n = 1'b1;
    @(negedge clk);

    // R3: matching short address, prefix 5 unit 3
    send_bits(24'h53, 8, 1'b0);
    expect_out(1'b1, 1'b0, 4'h3, "R3 short match");
    @(negedge clk);
    check(wake == 1'b0, "R7 wake single cycle", wake, 0);
    // R10: payload bits do not change the verdict
    send_bits(24'hF0, 8, 1'b0);
    check(hit == 1'b1 && unit_id == 4'h3, "R10 payload ignored", {hit, unit_id}, 8'h13);
    end_msg("R9 end clears match");

    // R8: mismatch, then matching bits in the same message
    send_bits(24'h73, 8, 1'b0);
    expect_out(1'b0, 1'b0, 4'h0, "R8 short mismatch");
    @(negedge clk);
    send_bits(24'h53, 8, 1'b0);
    check(hit == 1'b0 && wake == 1'b0, "R8 rest of message ignored", {hit, wake}, 0);
    end_msg("R9 end after mismatch");

    // R5: broadcast on a listened channel and an unlisted one
    send_bits(24'h02, 8, 1'b0);
    expect_out(1'b1, 1'b1, 4'h2, "R5 broadcast channel 2");
    @(negedge clk);
    end_msg("R9 end after broadcast");
    send_bits(24'h03, 8, 1'b0);
    expect_out(1'b0, 1'b0, 4'h0, "R5 unlisted channel 3");
    @(negedge clk);
    end_msg("R9 end after unlisted");

    // R6: full address, no verdict after 8 bits
    send_bits(24'hF3, 8, 1'b0);
    check(hit == 1'b0 && wake == 1'b0, "R6 no verdict at bit 8", {hit, wake}, 0);
    send_bits(24'hA5C7, 16, 1'b0);
    expect_out(1'b1, 1'b0, 4'h7, "R6 full match");
    @(negedge clk);
    end_msg("R9 end after full");
    send_bits(24'hF3A5D7, 24, 1'b0);
    expect_out(1'b0, 1'b0, 4'h0, "R6 full mismatch");
    @(negedge clk);
    end_msg("R9 end after full mismatch");

    // R2: bits with idle gaps
    send_bits(24'h5A, 8, 1'b1);
    check(hit == 1'b1 && unit_id == 4'hA, "R2 gapped bits match", {hit, unit_id}, 8'h1A);
    end_msg("R9 end after gapped");

    // R9: bit offered together with msg_end is discarded
    msg_end   = 1'b1;
    bit_valid = 1'b1;
    bit_data  = 1'b1;
    @(negedge clk);
    msg_end   = 1'b0;
    bit_valid = 1'b0;
    send_bits(24'h53, 8, 1'b0);
    expect_out(1'b1, 1'b0, 4'h3, "R9 bit with msg_end discarded");
    @(negedge clk);
    end_msg("R9 end after discard test");

    // R4: unassigned short prefix
    short_pfx_vld = 1'b0;
    send_bits(24'h53, 8, 1'b0);
    expect_out(1'b0, 1'b0, 4'h0, "R4 unassigned short rejected");
    @(negedge clk);
    end_msg("R9 end R4a");
    send_bits(24'hF3A5C1, 24, 1'b0);
    expect_out(1'b1, 1'b0, 4'h1, "R4 full still matches");
    @(negedge clk);
    end_msg("R9 end R4b");

    // R4: prefix register of 0 is not a short identity
    short_pfx     = 4'h0;
    short_pfx_vld = 1'b1;
    chan_mask     = 16'h0000;
    send_bits(24'h01, 8, 1'b0);
    expect_out(1'b0, 1'b0, 4'h0, "R4 zero prefix register");
    @(negedge clk);
    end_msg("R9 end R4c");

    // R3: highest usable short prefix
    short_pfx = 4'hE;
    send_bits(24'hE1, 8, 1'b0);
    expect_out(1'b1, 1'b0, 4'h1, "R3 prefix 14 match");
    @(negedge clk);
    end_msg("R9 end R3 boundary");

    repeat (3) @(negedge clk);
    check(sb_q.size() == 0, "scoreboard drained", sb_q.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule